// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus side of a byte-wide serial memory that sits on a two-wire bus (one clock line and one data line, both open drain). The block runs on a fast system clock. It oversamples the bus clock and data lines and decides from the sampled values when a start or a stop is on the bus. It receives the slave address and compares it with a fixed device-type code and three strap pins. It acknowledges by pulling the data line low. It then takes in a word address and data bytes, or it sends data bytes back to the master.

The storage array is outside the block. The block drives a word address and a one-cycle write strobe with the write data. It reads the array through an asynchronous read path: the read data must follow the presented address within the same cycle. The data line has no driver of its own here. The block outputs only a "pull low" enable, and an external open-drain pad or a wired-AND model combines it with the line.

A write sets the internal word address, and that address then steps after every stored byte. A read starts at the current word address. A random read is a word-address write followed by a repeated start. Each read byte moves the address on by one, and the address wraps at the top of the space.

Top module: `twm_slave`

## Requirements
- R1: A start (data falling while clock is high) restarts slave-address reception from any state, including in the middle of a transfer, and a stop (data rising while clock is high) returns the block to idle, after which it ignores the bus until the next start.
- R2: Before the first start, and after an address mismatch, the block never pulls the data line low and issues no write strobe, whatever bytes are clocked.
- R3: The first byte after a start is taken MSB first. The block acknowledges by pulling data low throughout the ninth clock only if bits 7..4 equal 1010 and bits 3..1 equal strap[2:0]. Bit 0 selects the direction, 1 for read and 0 for write.
- R4: In a write, the block acknowledges the word-address byte and every following data byte. Each data byte produces one single-cycle memWe pulse that carries the byte on memWdata and its target on memAddr. The address then steps by one, wrapping from 255 to 0.
- R5: In a read, the block drives the byte at the current word address MSB first. The data line changes only while the clock is low.
- R6: When the master acknowledges a read byte, the next byte comes from the next address, wrapping from 255 to 0. A later read without a word-address write continues from the address after the last byte sent.
- R7: When the master does not acknowledge a read byte, the block releases the data line and sends nothing more (further clocks read back all ones) until a stop or a start.
- R8: The data line is never driven high. sdaPull is 1 only during an acknowledge or a 0 data bit, and after a stop it is 0.
- R9: After reset, sdaPull is 0, memWe is 0 and memAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Pin-strapped low bits of the slave address |
| sdaPull | output | 1 | 1 pulls the data line low, 0 releases it |
| memAddr | output | ADDR_W | Current word address to the array |
| memWe | output | 1 | One-cycle write strobe |
| memWdata | output | 8 | Byte to store while memWe is high |
| memRdata | input | 8 | Array contents at memAddr, same cycle |

## Verification
The acknowledge of a written data byte and the write strobe for that byte start in the same cycle of the same bus clock fall. The following address step can be the 255-to-0 wrap. A page write that starts at address 254 exercises this: the bench requires an acknowledge on every byte and requires each byte to land at 254, 255 and 0. A read is then issued from 255 with acknowledge, and it must return the wrapped contents in order. A second coincidence is a repeated start that arrives right after an acknowledge. Detecting it must take priority over the byte counter's own transition. A random read exercises this and must return the byte at the address that was just written.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_WORDADDR, ST_WORDACK,
    ST_WRDATA, ST_WRACK, ST_RDDATA, ST_RDACK, ST_WAITSTOP
  } state_t;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftTx;
    logic loadAddr;
    logic wrByte;
    logic loadTx;
    logic incAddr;
    logic ackDrive;
    logic txDrive;
  } strobe_t;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ;

  // bus idles high, so reset the samplers high as well
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], scl};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclQ    <= sclPipe[STAGES-1];
      sdaQ    <= sdaPipe[STAGES-1];
    end
  end

  assign sclHigh  = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclHigh & ~sclQ;
  assign sclFall  = ~sclHigh & sclQ;
  assign startDet = sclHigh & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclHigh & sclQ & ~sdaQ & sdaS;
endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startDet,
  input  logic    stopDet,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    sdaS,
  input  logic    rxFull,
  input  logic    txLast,
  input  logic    devMatch,
  input  logic    rwBit,
  output strobe_t stb
);
  state_t state, stateNext;
  logic   ackSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_RDACK && sclRise) ackSeen <= ~sdaS;
    end
  end

  always_comb begin
    stateNext    = state;
    stb          = '0;
    stb.ackDrive = (state == ST_DEVACK) || (state == ST_WORDACK) || (state == ST_WRACK);
    stb.txDrive  = (state == ST_RDDATA);
    if (stopDet) begin
      stateNext = ST_IDLE;
    end else if (startDet) begin
      stateNext  = ST_DEVADDR;
      stb.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_WORDADDR, ST_WRDATA: begin
          if (sclRise && !rxFull) stb.shiftIn = 1'b1;
          if (sclFall && rxFull) begin
            stb.clrCnt = 1'b1;
            if (state == ST_DEVADDR) begin
              stateNext = devMatch ? ST_DEVACK : ST_IDLE;
            end else if (state == ST_WORDADDR) begin
              stb.loadAddr = 1'b1;
              stateNext    = ST_WORDACK;
            end else begin
              stb.wrByte = 1'b1;
              stateNext  = ST_WRACK;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            stb.clrCnt = 1'b1;
            if (rwBit) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_RDDATA;
            end else begin
              stateNext = ST_WORDADDR;
            end
          end
        end
        ST_WORDACK, ST_WRACK: begin
          if (sclFall) begin
            stb.clrCnt = 1'b1;
            stateNext  = ST_WRDATA;
          end
        end
        ST_RDDATA: begin
          if (sclFall) begin
            if (txLast) begin
              stb.clrCnt  = 1'b1;
              stb.incAddr = 1'b1;
              stateNext   = ST_RDACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RDACK: begin
          if (sclFall) begin
            if (ackSeen) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_RDDATA;
            end else begin
              stateNext = ST_WAITSTOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1: a detected start always lands in address reception
  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_DEVADDR));

  // R1: a detected stop always lands in idle
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE));

  // R7: after a refused read byte no byte is reloaded without a new start
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITSTOP && !startDet) |=> (state != ST_RDDATA));
endmodule

// File: rtl/twm_dpath.sv
module twm_dpath
  import twm_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        strap,
  input  logic              sdaS,
  input  strobe_t           stb,
  output logic              rxFull,
  output logic              txLast,
  output logic              devMatch,
  output logic              rwBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              sdaPull
);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [BYTE_W-1:0] shReg, txReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] wordAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      txReg    <= '1;
      bitCnt   <= '0;
      wordAddr <= '0;
      memWe    <= 1'b0;
      memWdata <= '0;
    end else begin
      if (stb.clrCnt) bitCnt <= '0;
      else if (stb.shiftIn || stb.shiftTx) bitCnt <= bitCnt + CNT_ONE;

      if (stb.shiftIn) shReg <= {shReg[BYTE_W-2:0], sdaS};

      if (stb.loadTx) txReg <= memRdata;
      else if (stb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};

      memWe <= stb.wrByte;
      if (stb.wrByte) memWdata <= shReg;

      // step after the strobe cycle so memAddr holds the target during it
      if (stb.loadAddr) wordAddr <= shReg[ADDR_W-1:0];
      else if (memWe || stb.incAddr) wordAddr <= wordAddr + ADDR_ONE;
    end
  end

  assign rxFull   = (bitCnt == CNT_FULL);
  assign txLast   = (bitCnt == CNT_LAST);
  assign devMatch = (shReg[7:1] == {DEV_TYPE, strap});
  assign rwBit    = shReg[0];
  assign memAddr  = wordAddr;
  assign sdaPull  = stb.ackDrive | (stb.txDrive & ~txReg[BYTE_W-1]);

  // R4: a write strobe lasts exactly one cycle
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R4: the word address steps by one right after every stored byte
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (memAddr == $past(memAddr) + ADDR_ONE));
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  output logic              sdaPull,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata
);
  logic    sclHigh, sdaS, sclRise, sclFall, startDet, stopDet;
  logic    rxFull, txLast, devMatch, rwBit;
  strobe_t stb;

  twm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  twm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .sdaS(sdaS),
    .rxFull(rxFull), .txLast(txLast), .devMatch(devMatch), .rwBit(rwBit),
    .stb(stb)
  );

  twm_dpath #(.ADDR_W(ADDR_W), .DEV_TYPE(DEV_TYPE)) u_dpath (
    .clk(clk), .rstN(rstN), .strap(strap), .sdaS(sdaS), .stb(stb),
    .rxFull(rxFull), .txLast(txLast), .devMatch(devMatch), .rwBit(rwBit),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .sdaPull(sdaPull)
  );

  // R5: the slave's drive never moves while the sampled clock stays high
  a_r5_sda_steady: assert property (@(posedge clk) disable iff (!rstN)
    (sclHigh && $past(sclHigh)) |-> $stable(sdaPull));
endmodule

// File: tb/twm_slave_tb.sv
module twm_slave_tb;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPull, memWe;
  logic [7:0] memAddr, memWdata, memRdata;
  logic sdaLine;
  logic [7:0] mem [0:255];
  int checks = 0, fails = 0, weCount = 0, steadyViol = 0;
  logic prevScl = 1'b1, prevPull = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine  = sdaM & ~sdaPull;
  assign memRdata = mem[memAddr];

  twm_slave u_dut (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(sdaLine), .strap(STRAP),
    .sdaPull(sdaPull), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr] <= memWdata;
      weCount <= weCount + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaPull != prevPull)) steadyViol <= steadyViol + 1;
    prevScl  <= sclM;
    prevPull <= sdaPull;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; q(Q); sclM = 1'b1; q(Q); sdaM = 1'b0; q(Q); sclM = 1'b0; q(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; q(Q); sclM = 1'b1; q(Q); sdaM = 1'b1; q(2 * Q);
  endtask

  task automatic sclLow();
    sdaM = 1'b1; q(Q); sclM = 1'b0; q(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; q(Q); sclM = 1'b1; q(2 * Q); sclM = 1'b0; q(Q);
    end
    sdaM = 1'b1; q(Q); sclM = 1'b1; q(Q);
    acked = ~sdaLine;
    q(Q); sclM = 1'b0; q(Q);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(Q); sclM = 1'b1; q(Q); b[i] = sdaLine; q(Q); sclM = 1'b0;
    end
    q(Q); sdaM = ~giveAck; q(Q); sclM = 1'b1; q(2 * Q); sclM = 1'b0; q(Q); sdaM = 1'b1;
  endtask

  task automatic tReset();
    chk("R9 sdaPull", int'(sdaPull), 0);
    chk("R9 memWe", int'(memWe), 0);
    chk("R9 memAddr", int'(memAddr), 0);
  endtask

  task automatic tNoStart();
    logic a;
    int we0 = weCount;
    sclLow();
    sendByte(DEV_W, a);
    chk("R2 no ack before start", int'(a), 0);
    sendByte(8'h10, a);
    chk("R2 no ack on later byte", int'(a), 0);
    chk("R2 no write before start", weCount - we0, 0);
    busStop();
  endtask

  task automatic tMismatch();
    logic a;
    int we0 = weCount;
    busStart();
    sendByte({4'b1010, 3'b011, 1'b0}, a);
    chk("R3 strap mismatch no ack", int'(a), 0);
    sendByte(8'h10, a);
    chk("R2 ignored after mismatch", int'(a), 0);
    busStart();
    sendByte({4'b1011, STRAP, 1'b0}, a);
    chk("R3 type mismatch no ack", int'(a), 0);
    sendByte(8'h55, a);
    chk("R2 ignored data", int'(a), 0);
    chk("R2 no write after mismatch", weCount - we0, 0);
    busStop();
  endtask

  task automatic tByteWrite();
    logic a;
    int we0 = weCount;
    busStart();
    sendByte(DEV_W, a);  chk("R3 address ack", int'(a), 1);
    sendByte(8'h10, a);  chk("R4 word address ack", int'(a), 1);
    sendByte(8'h5A, a);  chk("R4 data ack", int'(a), 1);
    busStop();
    chk("R4 one strobe", weCount - we0, 1);
    chk("R4 byte stored", int'(mem[8'h10]), 8'h5A);
    chk("R8 released after stop", int'(sdaPull), 0);
  endtask

  task automatic tPageWrap();
    logic a;
    int acks = 0;
    busStart();
    sendByte(DEV_W, a); acks += int'(a);
    sendByte(8'hFE, a); acks += int'(a);
    sendByte(8'h11, a); acks += int'(a);
    sendByte(8'h22, a); acks += int'(a);
    sendByte(8'h33, a); acks += int'(a);
    busStop();
    chk("R4 all bytes acked", acks, 5);
    chk("R4 at FE", int'(mem[8'hFE]), 8'h11);
    chk("R4 at FF", int'(mem[8'hFF]), 8'h22);
    chk("R4 wrap to 00", int'(mem[8'h00]), 8'h33);
  endtask

  task automatic tRandomRead();
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h10, a);
    busStart();
    sendByte(DEV_R, a);  chk("R1 repeated start read ack", int'(a), 1);
    readByte(1'b1, b);   chk("R5 read byte", int'(b), 8'h5A);
    readByte(1'b0, b);   chk("R6 next address", int'(b), 8'h11 ^ 8'h3C);
    readByte(1'b1, b);   chk("R7 silent after nack", int'(b), 8'hFF);
    busStop();
    chk("R8 released", int'(sdaPull), 0);
  endtask

  task automatic tReadWrap();
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'hFF, a);
    busStart();
    sendByte(DEV_R, a);
    readByte(1'b1, b);   chk("R6 byte at FF", int'(b), 8'h22);
    readByte(1'b0, b);   chk("R6 wrap read 00", int'(b), 8'h33);
    busStop();
    busStart();
    sendByte(DEV_R, a);  chk("R3 read ack", int'(a), 1);
    readByte(1'b0, b);   chk("R6 current address 01", int'(b), 8'h01 ^ 8'h3C);
    busStop();
  endtask

  task automatic tAfterStop();
    logic a;
    int we0 = weCount;
    sclLow();
    sendByte(DEV_R, a);
    chk("R1 idle after stop", int'(a), 0);
    sendByte(8'h00, a);
    chk("R1 still idle", int'(a), 0);
    chk("R1 no write while idle", weCount - we0, 0);
    busStop();
    chk("R5 no change while clock high", steadyViol, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    q(5);
    tReset();
    rstN = 1'b1;
    q(4 * Q);
    tNoStart();
    tMismatch();
    tByteWrite();
    tPageWrap();
    tRandomRead();
    tReadWrap();
    tAfterStop();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule